// File: doc/BRIEF.md
# Power Partition Toggle Controller

This block holds the power-switch enable and the isolation clamp of up to sixteen power partitions. Software drives it through a small synchronous register bus. A write to the toggle register flips the power state of one partition. A write to the release register takes down the isolation clamps of the partitions picked by a bit mask. A read of the status register returns one power bit for each partition.

A partition can change its power state only when the toggle write has its start bit set. Software reads the status register first and asks for a toggle only when the partition is not already in the state it wants. When a partition powers off, its clamp comes back on by itself. The clamp stays on until a later release write removes it while the partition is powered. The release-mask bits of two partitions are cross-wired, so each of those two bits controls the other partition's clamp.

Top module: `pwr_part_ctrl`

## Requirements
- R1: After reset every `pwr_en` bit is 0, every `clamp_on` bit is 1, and a status read returns 0.
- R2: A write to offset 0x30 with bit 8 set and bits [7:0] = k, where k < NUM_PART, inverts `pwr_en[k]`. The new value is visible right after the clock edge that samples the write.
- R3: A write to offset 0x30 with bit 8 clear changes no power or clamp output.
- R4: A toggle write whose index in bits [7:0] is NUM_PART or above leaves all power and clamp outputs unchanged.
- R5: A read at offset 0x38 returns bit N = `pwr_en[N]`, and all higher bits are 0. A read at any other offset returns 0.
- R6: A write to offset 0x34 clears `clamp_on[i]` for each set mask bit i (outside the crossed pair) when partition i is powered.
- R7: Mask bit 3 releases the clamp of partition 4, and mask bit 4 releases the clamp of partition 3.
- R8: When a partition powers off, its clamp is set again in the same update. A release aimed at an unpowered partition is ignored, so a partition that is off is always clamped.
- R9: A write to any other offset, including the status offset, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwr_en | output | 16 | Power-switch enable for each partition |
| clamp_on | output | 16 | Isolation clamp for each partition, 1 = clamped |

## Verification
Toggle and release writes are applied between clock edges. Their effect on `pwr_en`, `clamp_on` and the status bits is due after the one rising edge that samples the write, so every check is made at the falling edge that follows that rising edge. Read data follows the address combinationally, so a status read is checked a short delay after the address changes, with no clock edge in between. Reset is released through a two-stage synchronizer, so the first command is issued only after three further falling edges.

// File: rtl/pwrsw_pkg.sv
`timescale 1ns/1ps
package pwrsw_pkg;
  localparam int unsigned OFS_W       = 8;
  localparam logic [7:0]  OFS_TOGGLE  = 8'h30;
  localparam logic [7:0]  OFS_RELEASE = 8'h34;
  localparam logic [7:0]  OFS_STATUS  = 8'h38;
  localparam int unsigned IDX_W       = 8;
  localparam int unsigned START_BIT   = 8;

  // mask bit that releases partition p (two partitions are cross-wired)
  function automatic int unsigned mask_src(int unsigned p, int unsigned xa, int unsigned xb);
    if (p == xa)      return xb;
    else if (p == xb) return xa;
    else              return p;
  endfunction
endpackage

// File: rtl/pwrsw_rst_sync.sv
`timescale 1ns/1ps
module pwrsw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwrsw_decode.sv
`timescale 1ns/1ps
module pwrsw_decode
  import pwrsw_pkg::*;
#(
  parameter int unsigned NUM_PART = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned XA       = 3,
  parameter int unsigned XB       = 4
) (
  input  logic [OFS_W-1:0]    addr_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_PART-1:0] tgl_o,
  output logic [NUM_PART-1:0] rel_o
);
  logic             sel_toggle;
  logic             sel_release;
  logic             start;
  logic [IDX_W-1:0] idx;
  logic             idx_ok;
  logic             unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:NUM_PART];

  always_comb begin
    sel_toggle  = wr_i && (addr_i == OFS_TOGGLE);
    sel_release = wr_i && (addr_i == OFS_RELEASE);
    start       = wdata_i[START_BIT];
    idx         = wdata_i[IDX_W-1:0];
    idx_ok      = int'(idx) < NUM_PART;
  end

  for (genvar p = 0; p < NUM_PART; p++) begin : g_dec
    localparam int unsigned SRC = mask_src(p, XA, XB);
    assign tgl_o[p] = sel_toggle && start && idx_ok && (int'(idx) == p);
    assign rel_o[p] = sel_release && wdata_i[SRC];
  end
endmodule

// File: rtl/pwrsw_part.sv
`timescale 1ns/1ps
module pwrsw_part (
  input  logic clk,
  input  logic rst_ni,
  input  logic tgl_i,
  input  logic rel_i,
  output logic pwr_o,
  output logic clamp_o
);
  logic pwr_q, pwr_d;
  logic clamp_q, clamp_d;
  logic upd_en;

  always_comb begin
    upd_en  = tgl_i | rel_i;
    pwr_d   = pwr_q ^ tgl_i;
    clamp_d = clamp_q;
    if (tgl_i && pwr_q)      clamp_d = 1'b1;   // powering off: clamp again
    else if (rel_i && pwr_q) clamp_d = 1'b0;   // release only while powered
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q   <= 1'b0;
      clamp_q <= 1'b1;
    end else if (upd_en) begin
      pwr_q   <= pwr_d;
      clamp_q <= clamp_d;
    end
  end

  assign pwr_o   = pwr_q;
  assign clamp_o = clamp_q;

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_ni)
    tgl_i |=> (pwr_q != $past(pwr_q)));                      // R2
  AST_NO_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    !tgl_i |=> $stable(pwr_q));                               // R3
  AST_OFF_CLAMPED: assert property (@(posedge clk) disable iff (!rst_ni)
    !pwr_q |-> clamp_q);                                      // R8
  AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(clamp_q) |-> $past(rel_i) && $past(pwr_q));         // R6
endmodule

// File: rtl/pwr_part_ctrl.sv
`timescale 1ns/1ps
module pwr_part_ctrl
  import pwrsw_pkg::*;
#(
  parameter int unsigned NUM_PART = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned XA       = 3,
  parameter int unsigned XB       = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OFS_W-1:0]    bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PART-1:0] pwr_en,
  output logic [NUM_PART-1:0] clamp_on
);
  logic                rst_sync_n;
  logic [NUM_PART-1:0] tgl;
  logic [NUM_PART-1:0] rel;

  pwrsw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwrsw_decode #(
    .NUM_PART (NUM_PART),
    .DATA_W   (DATA_W),
    .XA       (XA),
    .XB       (XB)
  ) u_dec (
    .addr_i  (bus_addr),
    .wr_i    (bus_wr),
    .wdata_i (bus_wdata),
    .tgl_o   (tgl),
    .rel_o   (rel)
  );

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    pwrsw_part u_part (
      .clk     (clk),
      .rst_ni  (rst_sync_n),
      .tgl_i   (tgl[p]),
      .rel_i   (rel[p]),
      .pwr_o   (pwr_en[p]),
      .clamp_o (clamp_on[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_STATUS) bus_rdata[NUM_PART-1:0] = pwr_en;
  end

  AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == OFS_TOGGLE && int'(bus_wdata[IDX_W-1:0]) >= NUM_PART)
    |=> $stable(pwr_en) && $stable(clamp_on));                // R4
  AST_OTHER_OFS_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_wr || (bus_addr != OFS_TOGGLE && bus_addr != OFS_RELEASE))
    |=> $stable(pwr_en) && $stable(clamp_on));                // R9
  AST_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(pwr_en ^ $past(pwr_en)) <= 1);                 // R2
endmodule

// File: tb/pwr_part_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_part_ctrl_bench;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pwr_en, clamp_on;

  logic [NP-1:0] exp_pwr = '0;
  logic [NP-1:0] exp_clamp = '1;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_part_ctrl u_pwr_part_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_en(pwr_en), .clamp_on(clamp_on)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(string tag);
    chk({tag, " pwr_en"}, 32'(pwr_en), 32'(exp_pwr));
    chk({tag, " clamp_on"}, 32'(clamp_on), 32'(exp_clamp));
  endtask

  task automatic rd_status(string tag);
    bus_addr = 8'h38; bus_wr = 1'b0;
    #1 chk({tag, " status"}, bus_rdata, 32'(exp_pwr));
  endtask

  // one write, held across one rising edge; returns at the next falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; bus_addr = 8'h00;
  endtask

  task automatic toggle(int k);
    wr(8'h30, 32'h100 | 32'(k));
    if (k < NP) begin
      if (exp_pwr[k]) exp_clamp[k] = 1'b1;
      exp_pwr[k] = ~exp_pwr[k];
    end
  endtask

  task automatic release_mask(logic [NP-1:0] m);
    wr(8'h34, 32'(m));
    for (int p = 0; p < NP; p++) begin
      int s;
      s = (p == 3) ? 4 : (p == 4) ? 3 : p;
      if (m[s] && exp_pwr[p]) exp_clamp[p] = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk_outs("R1 reset");
    rd_status("R1 reset");
  endtask

  task automatic t_toggle;
    toggle(3);
    chk_outs("R2 on 3");
    rd_status("R2 R5 on 3");
    toggle(15);
    chk_outs("R2 on 15");
    rd_status("R5 after 15");
    bus_addr = 8'h30;
    #1 chk("R5 non-status read", bus_rdata, 32'h0);
  endtask

  task automatic t_no_start;
    wr(8'h30, 32'h0000_0005);
    chk_outs("R3 no start");
    wr(8'h30, 32'h0000_000F);
    chk_outs("R3 no start 15");
  endtask

  task automatic t_bad_index;
    toggle(16);
    chk_outs("R4 index 16");
    toggle(200);
    chk_outs("R4 index 200");
  endtask

  task automatic t_swap;
    release_mask(16'h0010);
    chk_outs("R7 bit4 frees 3");
    release_mask(16'h0008);
    chk_outs("R8 bit3 to off 4 ignored");
    toggle(4);
    release_mask(16'h0008);
    chk_outs("R7 bit3 frees 4");
  endtask

  task automatic t_plain_release;
    toggle(0);
    release_mask(16'h8001);
    chk_outs("R6 bits 0 and 15");
    release_mask(16'h0004);
    chk_outs("R8 bit2 off ignored");
  endtask

  task automatic t_reclamp;
    toggle(3);
    chk_outs("R8 off reclamps 3");
    release_mask(16'h0010);
    chk_outs("R8 release off 3 ignored");
    toggle(15);
    chk_outs("R8 off reclamps 15");
    rd_status("R5 after offs");
  endtask

  task automatic t_other_ofs;
    wr(8'h3C, 32'h0000_0105);
    chk_outs("R9 offset 3C");
    wr(8'h38, 32'hFFFF_FFFF);
    chk_outs("R9 status write");
    wr(8'h00, 32'h0000_0102);
    chk_outs("R9 offset 00");
    rd_status("R9 status");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_toggle();
    t_no_start();
    t_bad_index();
    t_swap();
    t_plain_release();
    t_reclamp();
    t_other_ofs();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule